// File: doc/BRIEF.md
# Display to Command Mode Sequencer

This block decides when a display controller leaves continuous pixel streaming for the command mode used to configure the panel, and when it goes back. The host presents an 8-bit command code with a one-cycle valid strobe. The block watches horizontal and vertical sync events from the timing generator. It drives three outputs: a display-enable, a data-enable that blanks the pixel data to black while the display path keeps running, and a command-mode flag. Some commands act on the next clock edge. Others wait for a chosen boundary: the next vertical sync, the next horizontal sync, or a vertical sync followed by one whole black frame.

A busy flag covers every deferred transition. Commands that arrive while it is high are dropped. Three codes make sense only when the panel is driven over the RGB interface. When the controller is strapped to the CPU interface, those codes are refused, and so are codes that are not defined. A refused code raises an error flag and leaves the mode untouched. The sync inputs can be single-cycle pulses or sync levels. With levels, the block detects their rising edges itself.

Top module: `disp_mode_seq`

## Requirements
- R1: After reset the block is in command mode with the display off: disp_en=0, data_en=0, cmd_mode=1, busy=0, err=0.
- R2: Code 0x00 turns on continuous display on the edge that takes it: disp_en=1, data_en=1, cmd_mode=0, busy stays 0.
- R3: Code 0x02 enters command mode on the edge that takes it, with the display off (disp_en=0, data_en=0, cmd_mode=1).
- R4: Code 0x11 leaves the outputs unchanged and holds busy=1 until the next vertical sync event. On that event's edge the block enters command mode with the display off. A horizontal sync does not end the wait.
- R5: Code 0x12 behaves like 0x11, except that the wait ends on the next horizontal sync event.
- R6: Code 0x13 waits for a vertical sync event, then shows one black frame (disp_en=1, data_en=0, cmd_mode=0, busy=1). At the following vertical sync event it enters command mode with the display off and clears busy.
- R7: With rgb_if=1, code 0x14 enters command mode at once with the display off, whatever the scan position.
- R8: With rgb_if=1, code 0x15 enters command mode at once with the display path left running and data disabled (disp_en=1, data_en=0, cmd_mode=1).
- R9: With rgb_if=1, code 0x01 holds busy=1 until the next vertical sync event. On that edge it starts continuous display (disp_en=1, data_en=1, cmd_mode=0).
- R10: With rgb_if=0, codes 0x01, 0x14 and 0x15 are refused. So is any undefined code, whatever rgb_if is. A refused code sets err=1 and leaves disp_en, data_en, cmd_mode and busy unchanged. The next accepted defined code clears err.
- R11: While busy=1, a command strobe has no effect on any output.
- R12: A sync event in the same cycle as the command strobe does not count toward that command's wait. Only events in later cycles end it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | CODE_W (8) | Command code |
| rgb_if | input | 1 | 1 = RGB panel interface, 0 = CPU panel interface |
| hsync_in | input | 1 | Horizontal sync event (pulse) or level |
| vsync_in | input | 1 | Vertical sync event (pulse) or level |
| disp_en | output | 1 | Display path enabled |
| data_en | output | 1 | Pixel data enabled; 0 with disp_en=1 gives black output |
| cmd_mode | output | 1 | Panel is in command mode |
| busy | output | 1 | A deferred transition is pending |
| err | output | 1 | Last command was refused |

## Verification
The bench targets the boundary choice. A horizontal sync is placed inside a vertical-sync wait: a design that ended on either sync would drop into command mode too early. It also fires a sync in the same cycle as the command strobe. A design that counted that event would finish at once and never show busy. The two-step black frame is checked between its two vertical syncs, where a wrong design would either skip the black frame or stay blank forever. Commands sent while busy, RGB-only codes sent in CPU mode, and an undefined code are all shown to leave the outputs alone. A design that let any of them through would visibly change mode.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

   localparam logic [7:0] OP_RUN        = 8'h00;
   localparam logic [7:0] OP_RUN_SYNC   = 8'h01;
   localparam logic [7:0] OP_CMD_NOW    = 8'h02;
   localparam logic [7:0] OP_CMD_AT_VS  = 8'h11;
   localparam logic [7:0] OP_CMD_AT_HS  = 8'h12;
   localparam logic [7:0] OP_CMD_BLACK  = 8'h13;
   localparam logic [7:0] OP_CMD_FREE   = 8'h14;
   localparam logic [7:0] OP_CMD_KEEP   = 8'h15;

   // steady output mode
   typedef enum logic [1:0] {
      M_CMD   = 2'd0,   // command mode, display off
      M_RUN   = 2'd1,   // streaming pixels
      M_BLANK = 2'd2,   // display running, data forced to black
      M_HOLD  = 2'd3    // command mode, display path kept alive
   } mode_t;

   // pending deferred transition
   typedef enum logic [2:0] {
      W_NONE      = 3'd0,
      W_VS_RUN    = 3'd1,
      W_VS_CMD    = 3'd2,
      W_HS_CMD    = 3'd3,
      W_VS_BLANK  = 3'd4
   } wait_t;

   typedef enum logic [3:0] {
      A_RUN, A_CMD_OFF, A_CMD_HOLD,
      A_WAIT_VS_RUN, A_WAIT_VS_CMD, A_WAIT_HS_CMD, A_WAIT_VS_BLANK,
      A_REJECT
   } action_t;

endpackage

// File: rtl/sync_evt.sv
module sync_evt #(
   parameter bit LEVEL_IN = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   output logic evt
);
   generate
      if (LEVEL_IN) begin : g_level
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= sync_in;
         end
         assign evt = sync_in & ~prev_q;
      end else begin : g_pulse
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign evt = sync_in;
      end
   endgenerate
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
   import disp_seq_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic [CODE_W-1:0] code,
   input  logic              rgb_if,
   output action_t           act
);
   localparam int HI_W = CODE_W - 8;

   generate
      if (CODE_W < 8) begin : g_bad_width
         $error("cmd_decode: CODE_W must be at least 8");
      end
   endgenerate

   logic       hi_clear;
   logic [7:0] op;

   generate
      if (HI_W > 0) begin : g_wide
         assign hi_clear = (code[CODE_W-1:8] == '0);
      end else begin : g_exact
         assign hi_clear = 1'b1;
      end
   endgenerate

   assign op = code[7:0];

   always_comb begin
      act = A_REJECT;
      if (hi_clear) begin
         unique case (op)
            OP_RUN:       act = A_RUN;
            OP_RUN_SYNC:  act = rgb_if ? A_WAIT_VS_RUN : A_REJECT;
            OP_CMD_NOW:   act = A_CMD_OFF;
            OP_CMD_AT_VS: act = A_WAIT_VS_CMD;
            OP_CMD_AT_HS: act = A_WAIT_HS_CMD;
            OP_CMD_BLACK: act = A_WAIT_VS_BLANK;
            OP_CMD_FREE:  act = rgb_if ? A_CMD_OFF  : A_REJECT;
            OP_CMD_KEEP:  act = rgb_if ? A_CMD_HOLD : A_REJECT;
            default:      act = A_REJECT;
         endcase
      end
   end
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
   import disp_seq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    take,
   input  action_t act,
   input  logic    hs_evt,
   input  logic    vs_evt,
   output mode_t   mode,
   output wait_t   pend,
   output logic    rej
);
   mode_t mode_d;
   wait_t pend_d;
   logic  rej_d;

   always_comb begin
      mode_d = mode;
      pend_d = pend;
      rej_d  = rej;
      if (pend != W_NONE) begin
         unique case (pend)
            W_VS_RUN:   if (vs_evt) begin mode_d = M_RUN;   pend_d = W_NONE;   end
            W_VS_CMD:   if (vs_evt) begin mode_d = M_CMD;   pend_d = W_NONE;   end
            W_HS_CMD:   if (hs_evt) begin mode_d = M_CMD;   pend_d = W_NONE;   end
            W_VS_BLANK: if (vs_evt) begin mode_d = M_BLANK; pend_d = W_VS_CMD; end
            default:    pend_d = W_NONE;
         endcase
      end else if (take) begin
         rej_d = 1'b0;
         unique case (act)
            A_RUN:           mode_d = M_RUN;
            A_CMD_OFF:       mode_d = M_CMD;
            A_CMD_HOLD:      mode_d = M_HOLD;
            A_WAIT_VS_RUN:   pend_d = W_VS_RUN;
            A_WAIT_VS_CMD:   pend_d = W_VS_CMD;
            A_WAIT_HS_CMD:   pend_d = W_HS_CMD;
            A_WAIT_VS_BLANK: pend_d = W_VS_BLANK;
            default:         rej_d  = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= M_CMD;
         pend <= W_NONE;
         rej  <= 1'b0;
      end else begin
         mode <= mode_d;
         pend <= pend_d;
         rej  <= rej_d;
      end
   end
endmodule

// File: rtl/disp_mode_seq.sv
module disp_mode_seq
   import disp_seq_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter bit SYNC_LEVELS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [CODE_W-1:0] cmd_code,
   input  logic              rgb_if,
   input  logic              hsync_in,
   input  logic              vsync_in,
   output logic              disp_en,
   output logic              data_en,
   output logic              cmd_mode,
   output logic              busy,
   output logic              err
);
   logic    hs_evt, vs_evt;
   action_t act;
   mode_t   mode;
   wait_t   pend;

   sync_evt #(.LEVEL_IN(SYNC_LEVELS)) u_hs (
      .clk(clk), .rst_n(rst_n), .sync_in(hsync_in), .evt(hs_evt));
   sync_evt #(.LEVEL_IN(SYNC_LEVELS)) u_vs (
      .clk(clk), .rst_n(rst_n), .sync_in(vsync_in), .evt(vs_evt));

   cmd_decode #(.CODE_W(CODE_W)) u_dec (
      .code(cmd_code), .rgb_if(rgb_if), .act(act));

   mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .take(cmd_valid), .act(act),
      .hs_evt(hs_evt), .vs_evt(vs_evt),
      .mode(mode), .pend(pend), .rej(err));

   assign disp_en  = (mode != M_CMD);
   assign data_en  = (mode == M_RUN);
   assign cmd_mode = (mode == M_CMD) || (mode == M_HOLD);
   assign busy     = (pend != W_NONE);
endmodule

module disp_mode_seq_chk #(
   parameter int CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [CODE_W-1:0] cmd_code,
   input logic              rgb_if,
   input logic              hsync_in,
   input logic              vsync_in,
   input logic              disp_en,
   input logic              data_en,
   input logic              cmd_mode,
   input logic              busy,
   input logic              err
);
   // R11: no sync while busy means nothing on the outputs moves
   assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !hsync_in && !vsync_in |=> $stable({disp_en, data_en, cmd_mode, busy}));

   // R3: immediate entry to command mode
   assert_cmd_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !busy && (cmd_code == CODE_W'(8'h02)) |=> cmd_mode && !disp_en && !err);

   // R10: refused RGB-only code in CPU mode
   assert_cpu_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !busy && !rgb_if && (cmd_code == CODE_W'(8'h14))
      |=> err && $stable({disp_en, data_en, cmd_mode}));

   // R4: busy only ends after a sync
   assert_busy_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(hsync_in || vsync_in));

   // R2: run command starts streaming without busy
   assert_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !busy && (cmd_code == '0) |=> disp_en && data_en && !cmd_mode && !busy);

   // R6: command mode never streams data
   assert_cmd_no_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_mode |-> !data_en);
endmodule

bind disp_mode_seq disp_mode_seq_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/tb_disp_mode_seq.sv
module tb_disp_mode_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_code = '0;
   logic       rgb_if = 1'b1;
   logic       hsync_in = 1'b0;
   logic       vsync_in = 1'b0;
   logic       disp_en, data_en, cmd_mode, busy, err;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   disp_mode_seq dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .rgb_if(rgb_if), .hsync_in(hsync_in), .vsync_in(vsync_in),
      .disp_en(disp_en), .data_en(data_en), .cmd_mode(cmd_mode),
      .busy(busy), .err(err));

   // expected vector order: {disp_en, data_en, cmd_mode, busy, err}
   task automatic check(input string req, input logic [4:0] exp);
      logic [4:0] act;
      act = {disp_en, data_en, cmd_mode, busy, err};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] c, input bit hs = 0, input bit vs = 0);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = c; hsync_in = hs; vsync_in = vs;
      @(negedge clk);
      cmd_valid = 1'b0; hsync_in = 1'b0; vsync_in = 1'b0;
   endtask

   task automatic pulse(input bit hs, input bit vs);
      @(negedge clk);
      hsync_in = hs; vsync_in = vs;
      @(negedge clk);
      hsync_in = 1'b0; vsync_in = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 reset", 5'b00100);
   endtask

   task automatic t_run;
      send(8'h00); check("R2 run", 5'b11000);
   endtask

   task automatic t_vsync_exit;
      send(8'h00);
      send(8'h11); check("R4 waiting", 5'b11010);
      pulse(1, 0); check("R4 hsync ignored", 5'b11010);
      pulse(0, 1); check("R4 vsync exit", 5'b00100);
   endtask

   task automatic t_hsync_exit;
      send(8'h00);
      send(8'h12, 1, 1); check("R12 same-cycle sync not counted", 5'b11010);
      pulse(1, 0); check("R5 hsync exit", 5'b00100);
   endtask

   task automatic t_busy_drop;
      send(8'h00);
      send(8'h11);
      send(8'h02); check("R11 command dropped while busy", 5'b11010);
      send(8'h00); check("R11 second command dropped", 5'b11010);
      pulse(0, 1); check("R11 original transition", 5'b00100);
   endtask

   task automatic t_black;
      send(8'h00);
      send(8'h13); check("R6 waiting", 5'b11010);
      pulse(0, 1); check("R6 black frame", 5'b10010);
      pulse(1, 0); check("R6 black holds on hsync", 5'b10010);
      pulse(0, 1); check("R6 command after black", 5'b00100);
   endtask

   task automatic t_rgb_codes;
      rgb_if = 1'b1;
      send(8'h01); check("R9 waiting", 5'b00110);
      pulse(1, 0); check("R9 hsync ignored", 5'b00110);
      pulse(0, 1); check("R9 display on vsync", 5'b11000);
      send(8'h15); check("R8 keep display path", 5'b10100);
      send(8'h00);
      send(8'h14); check("R7 free exit", 5'b00100);
      send(8'h00);
      send(8'h02); check("R3 immediate exit", 5'b00100);
   endtask

   task automatic t_cpu_reject;
      rgb_if = 1'b0;
      send(8'h00); check("R2 run in cpu mode", 5'b11000);
      send(8'h14); check("R10 0x14 refused", 5'b11001);
      send(8'h15); check("R10 0x15 refused", 5'b11001);
      send(8'h01); check("R10 0x01 refused", 5'b11001);
      send(8'h7e); check("R10 undefined refused", 5'b11001);
      send(8'h02); check("R10 err cleared by accepted", 5'b00100);
      rgb_if = 1'b1;
      send(8'h00);
      send(8'h33); check("R10 undefined refused in rgb", 5'b11001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_run();
      t_vsync_exit();
      t_hsync_exit();
      t_busy_drop();
      t_black();
      t_rgb_codes();
      t_cpu_reject();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule